// File: doc/BRIEF.md
# Composition Transfer Sequencer

This controller decides, for one frame, the order in which pixel regions and antialiasing samples move across a daisy-chained composition network. Once started, it walks every sample of every configured region. A region index is taken from a slot counter through a fixed bit reversal, so neighbouring regions are spread apart in time. Each transfer is sent to one of the shading boards, and the destination rotates in turn.

Before every transfer the sequencer waits until each board on the chain reports ready. It then pulses a transfer start and presents the region, the sample and the destination shader. It also drives a two-bit mode for every board: the head renderer drains its pixels, the other renderers merge by depth, the chosen shader sinks the result and the remaining shaders pass data through. The frame ends with a one-cycle completion pulse.

Top module: `xfer_sequencer`

## Requirements
- R1: After reset `busy`, `xfer_start` and `frame_done` are low and every board mode is pass (0).
- R2: `xfer_start` rises only in the cycle after one in which every bit of `board_ready` was high. While any board is not ready, no transfer starts.
- R3: Transfers run with the sample as the outer loop (0 upward) and a slot counter as the inner loop. The slot counter runs over all MAX_REGIONS slots. Each slot's bits are reversed to give the region, and regions at or above the region count are skipped. Every region-sample pair is sent exactly once per frame.
- R4: The destination shader is 0 for the first transfer of each frame. It advances by one per completed transfer and wraps to 0 after count-1.
- R5: `xfer_start` is a one-cycle pulse. After it, no further transfer starts until `xfer_done` is seen, and an `xfer_done` that arrives while no transfer is in flight has no effect.
- R6: When the region count is at least two, two consecutive transfers of a frame never carry the same region.
- R7: Board modes are 2 bits each, with board b at bits [2b+1:2b]. Boards 0..N_RENDER-1 are renderers and the next MAX_SHADERS boards are shaders 0 upward. The encoding is pass=0, merge=1, drain=2, sink=3. While busy, board 0 drains, the other renderers merge, the destination shader sinks and all other shaders pass. When idle, all boards pass.
- R8: `frame_done` pulses for one cycle after the done of the last transfer. `busy` falls in the following cycle.
- R9: A `frame_start` while busy is ignored, and the running frame continues unchanged.
- R10: The counts are latched at frame start. A count of zero is treated as one, and a count above its maximum is treated as the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Begin a frame (accepted only when idle) |
| num_regions | input | REG_W+1 | Regions per frame |
| num_samples | input | SMP_W+1 | Samples per region |
| num_shaders | input | SHD_W+1 | Shading boards in rotation |
| board_ready | input | N_BOARDS | Per-board ready for next transfer |
| xfer_done | input | 1 | Current transfer finished |
| xfer_start | output | 1 | One-cycle transfer start |
| region_id | output | REG_W | Region of the transfer |
| sample_id | output | SMP_W | Sample of the transfer |
| shader_id | output | SHD_W | Destination shader |
| board_mode | output | 2*N_BOARDS | Per-board compositor mode |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
On every cycle, the assertions check the following:
- the ready barrier in front of each start;
- the single-pulse start;
- that a start never overlaps an unfinished transfer;
- that the region and the shader index stay inside the latched counts;
- that consecutive transfers differ in region;
- that the completion pulse is followed by idle.

Only the bench's scenarios can show the rest. This covers the exact bit-reversed, sample-major order, and that every pair appears once. It also covers the round-robin restart at each frame, the clamping of zero and oversized counts, and that stray starts and dones leave the sequence intact.

// File: rtl/xseq_pkg.sv
`timescale 1ns/1ps
package xseq_pkg;
   typedef enum logic [1:0] {
      BM_PASS  = 2'd0,
      BM_MERGE = 2'd1,
      BM_DRAIN = 2'd2,
      BM_SINK  = 2'd3
   } board_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SCAN,
      ST_WAIT,
      ST_XFER,
      ST_FIN
   } seq_state_e;
endpackage

// File: rtl/xseq_region_walk.sv
`timescale 1ns/1ps
// Slot/sample walker: slot counter is bit-reversed into a region index.
module xseq_region_walk #(
   parameter  int MAX_REGIONS = 16,
   parameter  int MAX_SAMPLES = 8,
   localparam int REG_W       = $clog2(MAX_REGIONS),
   localparam int SMP_W       = $clog2(MAX_SAMPLES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             step,
   input  logic [REG_W:0]   cfg_regions,
   input  logic [SMP_W:0]   cfg_samples,
   output logic [REG_W-1:0] region,
   output logic [SMP_W-1:0] sample,
   output logic             hit,
   output logic             last
);
   logic [REG_W-1:0] slot;
   logic             slot_end;

   for (genvar b = 0; b < REG_W; b++) begin : g_rev
      assign region[b] = slot[REG_W-1-b];
   end

   assign slot_end = (slot == '1);
   assign hit      = ({1'b0, region} < cfg_regions);
   assign last     = slot_end && ({1'b0, sample} == (cfg_samples - 1'b1));

   always_ff @(posedge clk) begin
      if (!rst_n || init) begin
         slot   <= '0;
         sample <= '0;
      end else if (step) begin
         if (slot_end) begin
            slot   <= '0;
            sample <= sample + 1'b1;
         end else begin
            slot <= slot + 1'b1;
         end
      end
   end
endmodule

// File: rtl/xseq_shader_rr.sv
`timescale 1ns/1ps
// Round-robin destination pointer, wraps at the configured count.
module xseq_shader_rr #(
   parameter  int MAX_SHADERS = 4,
   localparam int SHD_W       = $clog2(MAX_SHADERS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             step,
   input  logic [SHD_W:0]   cfg_shaders,
   output logic [SHD_W-1:0] ptr
);
   always_ff @(posedge clk) begin
      if (!rst_n || init) begin
         ptr <= '0;
      end else if (step) begin
         if ({1'b0, ptr} == (cfg_shaders - 1'b1)) ptr <= '0;
         else                                     ptr <= ptr + 1'b1;
      end
   end
endmodule

// File: rtl/xseq_mode_map.sv
`timescale 1ns/1ps
// Per-board compositor mode decode.
module xseq_mode_map
   import xseq_pkg::*;
#(
   parameter  int N_RENDER    = 3,
   parameter  int MAX_SHADERS = 4,
   localparam int N_BOARDS    = N_RENDER + MAX_SHADERS,
   localparam int SHD_W       = $clog2(MAX_SHADERS)
) (
   input  logic                  active,
   input  logic [SHD_W-1:0]      dest,
   output logic [2*N_BOARDS-1:0] modes
);
   for (genvar r = 0; r < N_RENDER; r++) begin : g_rnd
      if (r == 0) begin : g_head
         assign modes[2*r +: 2] = active ? BM_DRAIN : BM_PASS;
      end else begin : g_body
         assign modes[2*r +: 2] = active ? BM_MERGE : BM_PASS;
      end
   end

   for (genvar j = 0; j < MAX_SHADERS; j++) begin : g_shd
      assign modes[2*(N_RENDER+j) +: 2] =
         (active && (dest == SHD_W'(j))) ? BM_SINK : BM_PASS;
   end
endmodule

// File: rtl/xfer_sequencer.sv
`timescale 1ns/1ps
module xfer_sequencer
   import xseq_pkg::*;
#(
   parameter  int MAX_REGIONS = 16,
   parameter  int MAX_SAMPLES = 8,
   parameter  int MAX_SHADERS = 4,
   parameter  int N_RENDER    = 3,
   localparam int REG_W       = $clog2(MAX_REGIONS),
   localparam int SMP_W       = $clog2(MAX_SAMPLES),
   localparam int SHD_W       = $clog2(MAX_SHADERS),
   localparam int N_BOARDS    = N_RENDER + MAX_SHADERS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_start,
   input  logic [REG_W:0]        num_regions,
   input  logic [SMP_W:0]        num_samples,
   input  logic [SHD_W:0]        num_shaders,
   input  logic [N_BOARDS-1:0]   board_ready,
   input  logic                  xfer_done,
   output logic                  xfer_start,
   output logic [REG_W-1:0]      region_id,
   output logic [SMP_W-1:0]      sample_id,
   output logic [SHD_W-1:0]      shader_id,
   output logic [2*N_BOARDS-1:0] board_mode,
   output logic                  busy,
   output logic                  frame_done
);
   initial begin
      assert (MAX_REGIONS >= 2 && MAX_REGIONS == (1 << REG_W))
         else $error("MAX_REGIONS must be a power of two, at least 2");
      assert (MAX_SAMPLES >= 2 && MAX_SAMPLES == (1 << SMP_W))
         else $error("MAX_SAMPLES must be a power of two, at least 2");
      assert (MAX_SHADERS >= 2 && MAX_SHADERS == (1 << SHD_W))
         else $error("MAX_SHADERS must be a power of two, at least 2");
      assert (N_RENDER >= 1) else $error("N_RENDER must be at least 1");
   end

   function automatic logic [REG_W:0] fit_r(input logic [REG_W:0] v);
      if (v == '0)                      return (REG_W+1)'(1);
      if (v > (REG_W+1)'(MAX_REGIONS))  return (REG_W+1)'(MAX_REGIONS);
      return v;
   endfunction
   function automatic logic [SMP_W:0] fit_s(input logic [SMP_W:0] v);
      if (v == '0)                      return (SMP_W+1)'(1);
      if (v > (SMP_W+1)'(MAX_SAMPLES))  return (SMP_W+1)'(MAX_SAMPLES);
      return v;
   endfunction
   function automatic logic [SHD_W:0] fit_h(input logic [SHD_W:0] v);
      if (v == '0)                      return (SHD_W+1)'(1);
      if (v > (SHD_W+1)'(MAX_SHADERS))  return (SHD_W+1)'(MAX_SHADERS);
      return v;
   endfunction

   seq_state_e     state;
   logic [REG_W:0] cfg_regions;
   logic [SMP_W:0] cfg_samples;
   logic [SHD_W:0] cfg_shaders;
   logic           launch, hit, last, walk_step, rr_step, all_ready;

   assign launch    = (state == ST_IDLE) && frame_start;
   assign all_ready = &board_ready;
   assign walk_step = ((state == ST_SCAN) && !hit && !last) ||
                      ((state == ST_XFER) && xfer_done && !last);
   assign rr_step   = (state == ST_XFER) && xfer_done;
   assign busy      = (state != ST_IDLE);
   assign frame_done = (state == ST_FIN);

   xseq_region_walk #(.MAX_REGIONS(MAX_REGIONS), .MAX_SAMPLES(MAX_SAMPLES)) u_walk (
      .clk(clk), .rst_n(rst_n), .init(launch), .step(walk_step),
      .cfg_regions(cfg_regions), .cfg_samples(cfg_samples),
      .region(region_id), .sample(sample_id), .hit(hit), .last(last));

   xseq_shader_rr #(.MAX_SHADERS(MAX_SHADERS)) u_rr (
      .clk(clk), .rst_n(rst_n), .init(launch), .step(rr_step),
      .cfg_shaders(cfg_shaders), .ptr(shader_id));

   xseq_mode_map #(.N_RENDER(N_RENDER), .MAX_SHADERS(MAX_SHADERS)) u_map (
      .active(busy), .dest(shader_id), .modes(board_mode));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         xfer_start  <= 1'b0;
         cfg_regions <= (REG_W+1)'(1);
         cfg_samples <= (SMP_W+1)'(1);
         cfg_shaders <= (SHD_W+1)'(1);
      end else begin
         xfer_start <= 1'b0;
         case (state)
            ST_IDLE: if (frame_start) begin
               cfg_regions <= fit_r(num_regions);
               cfg_samples <= fit_s(num_samples);
               cfg_shaders <= fit_h(num_shaders);
               state       <= ST_SCAN;
            end
            ST_SCAN: begin
               if (hit)       state <= ST_WAIT;
               else if (last) state <= ST_FIN;
            end
            ST_WAIT: if (all_ready) begin
               xfer_start <= 1'b1;
               state      <= ST_XFER;
            end
            ST_XFER: if (xfer_done) state <= last ? ST_FIN : ST_SCAN;
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xfer_sequencer_chk.sv
`timescale 1ns/1ps
module xfer_sequencer_chk #(
   parameter int N_BOARDS = 7,
   parameter int REG_W    = 4,
   parameter int SHD_W    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                busy,
   input logic                xfer_start,
   input logic                xfer_done,
   input logic                frame_done,
   input logic [N_BOARDS-1:0] board_ready,
   input logic [REG_W-1:0]    region_id,
   input logic [SHD_W-1:0]    shader_id,
   input logic [REG_W:0]      cfg_regions,
   input logic [SHD_W:0]      cfg_shaders
);
   logic             in_flight, have_prev;
   logic [REG_W-1:0] prev_region;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_flight   <= 1'b0;
         have_prev   <= 1'b0;
         prev_region <= '0;
      end else begin
         if (xfer_start)     in_flight <= 1'b1;
         else if (xfer_done) in_flight <= 1'b0;
         if (frame_done) have_prev <= 1'b0;
         else if (xfer_start) begin
            have_prev   <= 1'b1;
            prev_region <= region_id;
         end
      end
   end

   a_r2_ready_barrier: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> $past(&board_ready));
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start);
   a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> !in_flight);
   a_r3_region_range: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> ({1'b0, region_id} < cfg_regions));
   a_r4_shader_range: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ({1'b0, shader_id} < cfg_shaders));
   a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start && have_prev && (cfg_regions > 1)) |-> (region_id != prev_region));
   a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !busy);
   a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !in_flight);
endmodule

bind xfer_sequencer xfer_sequencer_chk #(
   .N_BOARDS(N_BOARDS), .REG_W(REG_W), .SHD_W(SHD_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .xfer_start(xfer_start),
   .xfer_done(xfer_done), .frame_done(frame_done), .board_ready(board_ready),
   .region_id(region_id), .shader_id(shader_id),
   .cfg_regions(cfg_regions), .cfg_shaders(cfg_shaders)
);

// File: tb/xfer_sequencer_tb_top.sv
`timescale 1ns/1ps
module xfer_sequencer_tb_top;
   localparam int MR = 16, MS = 8, MH = 4, NR = 3;
   localparam int RW = 4, SW = 3, HW = 2, NB = NR + MH;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0, frame_start = 1'b0, xfer_done = 1'b0;
   logic [RW:0]   num_regions = '0;
   logic [SW:0]   num_samples = '0;
   logic [HW:0]   num_shaders = '0;
   logic [NB-1:0] board_ready = '1;
   logic          xfer_start, busy, frame_done;
   logic [RW-1:0] region_id;
   logic [SW-1:0] sample_id;
   logic [HW-1:0] shader_id;
   logic [2*NB-1:0] board_mode;

   xfer_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .num_regions(num_regions), .num_samples(num_samples), .num_shaders(num_shaders),
      .board_ready(board_ready), .xfer_done(xfer_done), .xfer_start(xfer_start),
      .region_id(region_id), .sample_id(sample_id), .shader_id(shader_id),
      .board_mode(board_mode), .busy(busy), .frame_done(frame_done));

   int  n_chk = 0, n_bad = 0;
   bit  ended = 0;
   int  exp_r[$], exp_s[$], exp_h[$];
   int  cur_rc = 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int brev(input int i);
      int r = 0;
      for (int b = 0; b < RW; b++) if (i[b]) r |= 1 << (RW - 1 - b);
      return r;
   endfunction

   function automatic int fit(input int v, input int mx);
      if (v == 0) return 1;
      if (v > mx) return mx;
      return v;
   endfunction

   // R3/R4/R10 reference sequence
   task automatic build(input int r, input int s, input int h);
      int rc = fit(r, MR), sc = fit(s, MS), hc = fit(h, MH), shd = 0;
      cur_rc = rc;
      exp_r.delete(); exp_s.delete(); exp_h.delete();
      for (int si = 0; si < sc; si++)
         for (int i = 0; i < MR; i++)
            if (brev(i) < rc) begin
               exp_r.push_back(brev(i)); exp_s.push_back(si); exp_h.push_back(shd);
               shd = (shd + 1) % hc;
            end
   endtask

   task automatic start_frame(input int r, input int s, input int h);
      @(negedge clk);
      num_regions = r[RW:0]; num_samples = s[SW:0]; num_shaders = h[HW:0];
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic check_modes(input int dest);
      for (int b = 0; b < NB; b++) begin
         int want = (b == 0) ? 2 : (b < NR) ? 1 : ((b - NR) == dest) ? 3 : 0;
         chk(int'(board_mode[2*b +: 2]) == want, "R7", "board mode", int'(board_mode[2*b +: 2]), want);
      end
   endtask

   // Serve transfers until frame_done, comparing with the reference.
   task automatic drain(input bit poke);
      int  k = 0, guard = 0, prev = -1;
      bit  seen = 0;
      @(negedge clk);
      while (!seen && guard < 5000) begin
         guard++;
         if (frame_done) seen = 1;
         else if (xfer_start) begin
            if (k < exp_r.size()) begin
               chk(int'(region_id) == exp_r[k], "R3", "region", int'(region_id), exp_r[k]);
               chk(int'(sample_id) == exp_s[k], "R3", "sample", int'(sample_id), exp_s[k]);
               chk(int'(shader_id) == exp_h[k], "R4", "shader", int'(shader_id), exp_h[k]);
               check_modes(exp_h[k]);
               if (cur_rc > 1 && prev >= 0)
                  chk(int'(region_id) != prev, "R6", "repeated region", int'(region_id), prev);
            end else chk(0, "R3", "extra transfer", k, exp_r.size());
            prev = int'(region_id);
            k++;
            @(negedge clk);
            chk(!xfer_start, "R5", "start pulse width", int'(xfer_start), 0);
            @(negedge clk);
            chk(!xfer_start, "R5", "start before done", int'(xfer_start), 0);
            xfer_done = 1'b1;
            if (poke && k == 2) frame_start = 1'b1;  // R9: ignored while busy
            @(negedge clk);
            xfer_done = 1'b0; frame_start = 1'b0;
         end else @(negedge clk);
      end
      chk(seen, "R8", "frame_done seen", int'(seen), 1);
      chk(k == exp_r.size(), "R3", "transfer count", k, exp_r.size());
      @(negedge clk);
      chk(!busy, "R8", "busy after frame_done", int'(busy), 0);
      chk(board_mode == '0, "R7", "idle modes", int'(board_mode), 0);
   endtask

   task automatic t_reset;
      chk(!busy, "R1", "busy", int'(busy), 0);
      chk(!xfer_start, "R1", "xfer_start", int'(xfer_start), 0);
      chk(!frame_done, "R1", "frame_done", int'(frame_done), 0);
      chk(board_mode == '0, "R1", "board_mode", int'(board_mode), 0);
   endtask

   task automatic t_full;     // all regions, two samples, two shaders
      build(16, 2, 2); start_frame(16, 2, 2); drain(0);
   endtask

   task automatic t_partial_poke;  // R9: partial region count with a stray start
      build(11, 3, 3); start_frame(11, 3, 3); drain(1);
   endtask

   task automatic t_clamp;    // R10: zero and oversized counts
      build(0, 0, 0); start_frame(0, 0, 0); drain(0);
      build(31, 1, 7); start_frame(31, 1, 7); drain(0);
   endtask

   task automatic t_ready_gate;   // R2 and R5: barrier and stray done
      build(5, 2, 4);
      board_ready = '1; board_ready[4] = 1'b0;
      start_frame(5, 2, 4);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(!xfer_start, "R2", "start while not ready", int'(xfer_start), 0);
         xfer_done = (i == 4);   // R5: stray done outside a transfer
      end
      xfer_done = 1'b0;
      board_ready = '1;
      drain(0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full();
      t_partial_poke();
      t_clamp();
      t_ready_gate();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule